// File: doc/BRIEF.md
# Cyclic-Shift Omega Switch Fabric

The block is an eight-port, three-stage omega network of 2x2 switch cells, with a perfect-shuffle wiring pattern in front of every stage. A single shift amount `shift_k` controls it. From that amount the block works out the state of all twelve cells so that the word on input port `i` lands on output port `(i + shift_k) mod 8`. All eight words take their paths through the fabric at the same moment, and none of them blocks another.

Each word enters the fabric with a destination tag, which is `(i + shift_k) mod 8`. Every cell steers words by one bit of that tag: bit 2 in stage 0, bit 1 in stage 1 and bit 0 in stage 2. A word whose tag bit is 1 leaves on the cell's lower output. A cell crosses (setting 1) when the word on its upper input carries a tag bit of 1, and otherwise it passes straight through (setting 0).

If the two words entering a cell ever ask for the same output, a sticky error flag is raised. Under cyclic shifts this never happens. The fabric itself is combinational. Its result is captured into one output register stage.

The data path uses valid/ready handshakes on both sides:
- A vector is accepted on a rising clock edge when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or is being drained in that same cycle through `out_ready`.
- While `out_valid` is high and `out_ready` is low, the outputs hold and new input is refused.

Top module: `omega_shift_router`

## Requirements
- R1: One cycle after an accepted vector, output word `(i + k) mod 8` equals the accepted input word `i`, for every `i` and every `k` from 0 to 7. Word `i` occupies bits `[16*i+15 : 16*i]` of the data buses.
- R2: `cell_cfg` bit `4*j + c` holds the setting of cell `c` in stage `j` (0 = pass, 1 = cross). After a transfer with `k = 0`, every bit is 0.
- R3: After a transfer with `k = 4`, the four stage-0 cells cross and all the others pass, so `cell_cfg = 12'h00F`.
- R4: `route_err` is 0 after reset, and it stays 0 through transfers with every shift value from 0 to 7. It is sticky and is cleared only by reset.
- R5: `out_valid` is high in the cycle after a transfer.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `cell_cfg` hold their values whatever is presented at the input.
- R7: After reset, `out_valid` is 0 and `in_ready` is 1.
- R8: When the output is consumed and no new input is accepted, `out_valid` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| in_data | input | 128 | Eight 16-bit input words, word i at bits 16*i+15:16*i |
| shift_k | input | 3 | Cyclic shift amount |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | 128 | Eight 16-bit routed words |
| cell_cfg | output | 12 | Cell settings, bit 4*j+c for stage j, cell c |
| route_err | output | 1 | Sticky cell-contention flag |

## Verification
On every cycle, the assertions check several things. They confirm the full permutation for each pair of input port and shift value. They check the all-pass pattern for a zero shift and the stage-0-only pattern for a half-rotation. They also check that the error flag never rises, that the output holds under back-pressure, and that the valid signal behaves correctly on acceptance and on drain. Only the bench scenarios can show the reset values, and that a vector offered during a stall is refused and not lost, by later accepting it and routing it correctly. They also show the whole sweep of shift values on random data, checked against a shifted copy the bench builds itself.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // Left rotation of a port index by one bit over nbits bits (perfect shuffle).
  function automatic int shuffle_dst(input int port, input int nbits);
    int mask;
    mask = (1 << nbits) - 1;
    return ((port << 1) | (port >> (nbits - 1))) & mask;
  endfunction
endpackage

// File: rtl/omega_cell.sv
module omega_cell #(
  parameter int W       = 19,
  parameter int TAG_BIT = 18
) (
  input  logic [W-1:0] up_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] lo_o,
  output logic         cross_o,
  output logic         clash_o
);
  always_comb begin
    cross_o = up_i[TAG_BIT];
    clash_o = (up_i[TAG_BIT] == lo_i[TAG_BIT]);
    up_o    = cross_o ? lo_i : up_i;
    lo_o    = cross_o ? up_i : lo_i;
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N       = 8,
  parameter int LOG_N   = 3,
  parameter int W       = 19,
  parameter int TAG_BIT = 18
) (
  input  logic [N*W-1:0]   bus_i,
  output logic [N*W-1:0]   bus_o,
  output logic [N/2-1:0]   cross_o,
  output logic [N/2-1:0]   clash_o
);
  localparam int CELLS = N / 2;

  logic [N*W-1:0] shuffled;

  for (genvar p = 0; p < N; p++) begin : g_shuf
    localparam int Q = omega_pkg::shuffle_dst(p, LOG_N);
    assign shuffled[Q*W +: W] = bus_i[p*W +: W];
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    omega_cell #(.W(W), .TAG_BIT(TAG_BIT)) cell_i (
      .up_i    (shuffled[(2*c)*W +: W]),
      .lo_i    (shuffled[(2*c+1)*W +: W]),
      .up_o    (bus_o[(2*c)*W +: W]),
      .lo_o    (bus_o[(2*c+1)*W +: W]),
      .cross_o (cross_o[c]),
      .clash_o (clash_o[c])
    );
  end
endmodule

// File: rtl/omega_shift_router.sv
module omega_shift_router #(
  parameter int LOG_N  = 3,
  parameter int DATA_W = 16,
  localparam int N     = 1 << LOG_N,
  localparam int CELLS = N / 2,
  localparam int CFG_W = LOG_N * CELLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [N*DATA_W-1:0] in_data,
  input  logic [LOG_N-1:0]    shift_k,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N*DATA_W-1:0] out_data,
  output logic [CFG_W-1:0]    cell_cfg,
  output logic                route_err
);
  localparam int TW = DATA_W + LOG_N;

  logic [N*TW-1:0]     bus [LOG_N+1];
  logic [CFG_W-1:0]    cfg_comb;
  logic [CFG_W-1:0]    clash_all;
  logic [N*DATA_W-1:0] routed;
  logic                fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // Tag each word with its destination port.
  for (genvar i = 0; i < N; i++) begin : g_tag
    localparam logic [LOG_N-1:0] IDX = LOG_N'(i);
    logic [LOG_N-1:0] dest;
    assign dest = shift_k + IDX;
    assign bus[0][i*TW +: TW] = {dest, in_data[i*DATA_W +: DATA_W]};
  end

  for (genvar j = 0; j < LOG_N; j++) begin : g_stage
    omega_stage #(
      .N(N), .LOG_N(LOG_N), .W(TW), .TAG_BIT(DATA_W + LOG_N - 1 - j)
    ) stage_i (
      .bus_i   (bus[j]),
      .bus_o   (bus[j+1]),
      .cross_o (cfg_comb[j*CELLS +: CELLS]),
      .clash_o (clash_all[j*CELLS +: CELLS])
    );
  end

  for (genvar p = 0; p < N; p++) begin : g_strip
    assign routed[p*DATA_W +: DATA_W] = bus[LOG_N][p*TW +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      cell_cfg  <= '0;
      route_err <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= routed;
        cell_cfg  <= cfg_comb;
        if (|clash_all) route_err <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Assertions
  for (genvar ai = 0; ai < N; ai++) begin : g_chk_i
    for (genvar ak = 0; ak < N; ak++) begin : g_chk_k
      AST_SHIFT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && shift_k == LOG_N'(ak)) |=>
          out_data[((ai+ak)%N)*DATA_W +: DATA_W] == $past(in_data[ai*DATA_W +: DATA_W])); // R1
    end
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && shift_k == '0) |=> cell_cfg == '0); // R2

  AST_HALF_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && shift_k == LOG_N'(N/2)) |=> cell_cfg == CFG_W'((1 << CELLS) - 1)); // R3

  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !route_err); // R4

  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(cell_cfg))); // R6

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
endmodule

// File: tb/omega_shift_router_tb_top.sv
module omega_shift_router_tb_top;
  localparam int LOG_N = 3;
  localparam int DW    = 16;
  localparam int N     = 8;
  localparam int BW    = N * DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [BW-1:0] in_data;
  logic [2:0]    shift_k;
  logic          out_valid;
  logic          out_ready;
  logic [BW-1:0] out_data;
  logic [11:0]   cell_cfg;
  logic          route_err;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #5 clk = ~clk;

  omega_shift_router #(.LOG_N(LOG_N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .shift_k(shift_k), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cell_cfg(cell_cfg),
    .route_err(route_err)
  );

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] shifted(input logic [BW-1:0] d, input int k);
    logic [BW-1:0] r;
    for (int i = 0; i < N; i++) r[((i + k) % N)*DW +: DW] = d[i*DW +: DW];
    return r;
  endfunction

  function automatic logic [BW-1:0] rand_vec();
    logic [BW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  // Present one vector for one edge; sample just after the capturing edge.
  task automatic send(input logic [BW-1:0] d, input logic [2:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; shift_k = k;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0; shift_k = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 out_valid after reset", BW'(out_valid), BW'(0));
    check("R7 in_ready after reset", BW'(in_ready), BW'(1));
    check("R4 route_err after reset", BW'(route_err), BW'(0));
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_all_shifts();
    for (int k = 0; k < N; k++) begin
      logic [BW-1:0] d;
      d = rand_vec();
      @(negedge clk);
      in_valid = 1'b1; in_data = d; shift_k = 3'(k);
      @(posedge clk); #1;
      check($sformatf("R5 out_valid k=%0d", k), BW'(out_valid), BW'(1));
      check($sformatf("R1 data k=%0d", k), out_data, shifted(d, k));
      check($sformatf("R4 route_err k=%0d", k), BW'(route_err), BW'(0));
      @(negedge clk); in_valid = 1'b0;
    end
  endtask

  task automatic t_zero_cfg();
    logic [BW-1:0] d;
    d = rand_vec();
    send(d, 3'd0);
    check("R2 cfg k=0 all pass", BW'(cell_cfg), BW'(12'h000));
    check("R1 data k=0 identity", out_data, d);
  endtask

  task automatic t_half_cfg();
    logic [BW-1:0] d;
    d = rand_vec();
    send(d, 3'd4);
    check("R3 cfg k=4", BW'(cell_cfg), BW'(12'h00F));
    check("R1 data k=4", out_data, shifted(d, 4));
  endtask

  task automatic t_stall();
    logic [BW-1:0] a, b;
    a = rand_vec(); b = rand_vec();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = a; shift_k = 3'd3;
    @(posedge clk); #1;
    check("R6 stall captured A", out_data, shifted(a, 3));
    @(negedge clk);
    in_data = b; shift_k = 3'd0;
    #1;
    check("R6 in_ready low while stalled", BW'(in_ready), BW'(0));
    @(posedge clk); #1;
    check("R6 data held", out_data, shifted(a, 3));
    check("R6 valid held", BW'(out_valid), BW'(1));
    check("R6 cfg held (k=3 not k=0)", BW'(cell_cfg == 12'h000), BW'(0));
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    check("R6 refused vector B taken after release", out_data, b);
    check("R2 cfg of B k=0", BW'(cell_cfg), BW'(12'h000));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_drain();
    send(rand_vec(), 3'd5);
    check("R5 valid before drain", BW'(out_valid), BW'(1));
    @(posedge clk); #1;
    check("R8 valid falls after consume", BW'(out_valid), BW'(0));
    check("R4 route_err still low", BW'(route_err), BW'(0));
  endtask

  initial begin
    t_reset();
    t_all_shifts();
    t_zero_cfg();
    t_half_cfg();
    t_stall();
    t_drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule